// File: doc/BRIEF.md
# PCI Configuration Cycle Requester

This block turns CPU accesses that land in a 64 KB configuration window into PCI configuration transactions toward a simple target interface. The window starts 0x10000 above the base of the second slave area; the lower 64 KB of that area belongs to I/O and is not claimed here. Inside the window, address bits [15:8] name the device and function (device in [15:11], function in [10:8]) and bits [7:0] name the register offset. The target bus number is taken from bits [23:16] of a control word that software writes beforehand.

On bus 0 the device number is raised by six, so device 0 reaches the first IDSEL line above the non-standard ones. A request for bus 0xFF, device 0, function 0 addresses the host's own function and goes out as bus 0, devfn 0. Data crosses the bus in little-endian order, so write data and read data are byte-swapped between the CPU side and the PCI side. A target that never acknowledges is treated as missing: after a bounded wait the block reports a master abort and returns all ones. Completion and error are kept in two sticky status bits that software clears by writing 1.

The controller is a four-state machine. IDLE waits for a request. From IDLE, a request that is rejected or that names a device above 15 goes straight to RESPOND. Any other accepted request goes to GRANT_WAIT. GRANT_WAIT holds while a DMA transfer owns the bus and moves to CYCLE once it is free. CYCLE drives the configuration request. It goes to RESPOND on an acknowledge, or on timeout expiry with an abort. RESPOND presents the one-cycle response and returns to IDLE.

Top module: `cfg_requester`

## Requirements
- R1: Only an address whose bits [31:16] equal the window's upper half (area base + 0x10000) starts a cycle; any other address, including the I/O half below it, returns response code 2 (rejected) and issues no cycle.
- R2: A window address with non-zero bits [1:0] returns response code 2 without a cycle and leaves the status bits unchanged; a driven cycle always carries an offset with bits [1:0] equal to zero.
- R3: The cycle carries register offset = address bits [7:0], and the function bits (address [10:8]) pass unchanged; bus, devfn and offset stay stable while the request is held.
- R4: The target bus is control-word bits [23:16]; for any bus other than 0 and the host case, devfn equals address bits [15:8].
- R5: On bus 0 the device number on the bus is the requested device plus 6.
- R6: Bus 0xFF with address bits [15:8] = 0 is issued as bus 0, devfn 0; bus 0xFF with any other devfn is issued unchanged on bus 0xFF.
- R7: A requested device number above 15 issues no cycle and returns response code 1 (abort) with read data 0xFFFFFFFF, and sets both status bits.
- R8: Write data on the bus is the CPU word byte-reversed, and read data to the CPU is the bus word byte-reversed.
- R9: Status bit 20 (done) and bit 19 (error) in the status word are sticky. Accepting a request clears both. Bit 20 sets when the request finishes, and bit 19 sets with it on abort. Writing 1 to either bit clears it. Writes to other bits have no effect, and all other status bits read 0.
- R10: While the DMA-busy input is high, no configuration request is driven and status bit 20 stays clear; the cycle starts once DMA-busy drops.
- R11: If the target does not acknowledge within TIMEOUT_CYC cycles of the request, the request is withdrawn and the response is code 1 with read data 0xFFFFFFFF and both status bits set.
- R12: Each accepted or rejected request yields exactly one response pulse of one cycle; a request arriving while the block is busy is ignored. A successful response has code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word; bits [23:16] select the target bus |
| stat_wr | input | 1 | Status write strobe (write 1 to clear) |
| stat_wdata | input | 32 | Status write data; bits 20 and 19 are meaningful |
| stat_word | output | 32 | Status word: bit 20 done, bit 19 error |
| req_valid | input | 1 | CPU access request, one cycle |
| req_write | input | 1 | 1 = configuration write |
| req_addr | input | 32 | CPU address |
| req_wdata | input | 32 | CPU write data (big-endian view) |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_code | output | 2 | 0 ok, 1 abort, 2 rejected |
| resp_rdata | output | 32 | Read data (big-endian view) |
| dma_busy | input | 1 | DMA transfer owns the bus |
| cfg_req | output | 1 | Configuration cycle request, held until finish |
| cfg_write | output | 1 | Cycle direction, 1 = write |
| cfg_bus | output | 8 | Bus number on the cycle |
| cfg_devfn | output | 8 | Device/function on the cycle |
| cfg_reg | output | 8 | Register offset on the cycle |
| cfg_wdata | output | 32 | Little-endian write data |
| cfg_ack | input | 1 | Target acknowledge |
| cfg_rdata | input | 32 | Little-endian read data from target |

## Verification
A wrong state in the controller shows up at the ports within one or two cycles of its cause. A cycle that starts under DMA ownership is visible as cfg_req rising right after a busy cycle. A missed status clear shows bit 20 high while the request is driven. A stuck RESPOND state shows resp_valid for two cycles in a row. Mapping faults show up on the first cycle that reaches the target: a wrong bus or devfn, or a device-6 offset missing on bus 0. Swap faults show up in the first read or write data compared. A timeout counter that is off by one changes the length of the cfg_req window, and the bench sees that in the abort result.

// File: rtl/cfg_req_pkg.sv
package cfg_req_pkg;

    typedef enum logic [1:0] {
        RSP_OK      = 2'd0,
        RSP_ABORT   = 2'd1,
        RSP_INVALID = 2'd2
    } rsp_code_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GRANT_WAIT,
        ST_CYCLE,
        ST_RESPOND
    } req_state_e;

    // software decodes these positions
    localparam int STAT_DONE_BIT = 20;
    localparam int STAT_ERR_BIT  = 19;

    function automatic logic [31:0] swap32(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode #(
    parameter logic [31:0] AREA1_BASE = 32'hC000_0000,
    parameter int          DEV_SHIFT  = 6,
    parameter int          MAX_DEV    = 15
) (
    input  logic [31:0] addr,
    input  logic [7:0]  bus_sel,
    output logic        invalid,
    output logic        dev_abort,
    output logic [7:0]  map_bus,
    output logic [7:0]  map_devfn,
    output logic [7:0]  map_reg
);
    localparam logic [31:0] WIN_BASE = AREA1_BASE + 32'h0001_0000;
    localparam logic [15:0] WIN_TAG  = WIN_BASE[31:16];
    localparam logic [7:0]  HOST_BUS = 8'hFF;

    logic [4:0] dev;
    logic [4:0] dev_adj;
    logic       in_win;
    logic       host_fn;

    always_comb begin
        dev       = addr[15:11];
        dev_adj   = dev + 5'(DEV_SHIFT);
        in_win    = (addr[31:16] == WIN_TAG);
        invalid   = !in_win || (addr[1:0] != 2'b00);
        dev_abort = (int'(dev) > MAX_DEV);
        host_fn   = (bus_sel == HOST_BUS) && (addr[15:8] == 8'h00);
        map_reg   = addr[7:0];
        if (host_fn) begin
            map_bus   = 8'h00;
            map_devfn = 8'h00;
        end else if (bus_sel == 8'h00) begin
            map_bus   = 8'h00;
            map_devfn = {dev_adj, addr[10:8]};
        end else begin
            map_bus   = bus_sel;
            map_devfn = addr[15:8];
        end
    end
endmodule

// File: rtl/cfg_req_fsm.sv
module cfg_req_fsm
    import cfg_req_pkg::*;
#(
    parameter int TIMEOUT_CYC = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_valid,
    input  logic      dec_invalid,
    input  logic      dec_abort,
    input  logic      dma_busy,
    input  logic      cfg_ack,
    output logic      accept,
    output logic      cyc_active,
    output logic      resp_valid,
    output rsp_code_e resp_code,
    output logic      finish,
    output logic      fin_ok,
    output logic      set_done,
    output logic      set_err
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);

    req_state_e state_q, state_nxt;
    rsp_code_e  code_q, code_nxt;
    logic [TW-1:0] tmo_q;

    always_comb begin
        state_nxt = state_q;
        code_nxt  = code_q;
        accept    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (dec_invalid) begin
                        state_nxt = ST_RESPOND;
                        code_nxt  = RSP_INVALID;
                    end else begin
                        accept = 1'b1;
                        if (dec_abort) begin
                            state_nxt = ST_RESPOND;
                            code_nxt  = RSP_ABORT;
                        end else begin
                            state_nxt = ST_GRANT_WAIT;
                        end
                    end
                end
            end
            ST_GRANT_WAIT: begin
                if (!dma_busy) state_nxt = ST_CYCLE;
            end
            ST_CYCLE: begin
                if (cfg_ack) begin
                    state_nxt = ST_RESPOND;
                    code_nxt  = RSP_OK;
                end else if (tmo_q == TW'(TIMEOUT_CYC - 1)) begin
                    state_nxt = ST_RESPOND;
                    code_nxt  = RSP_ABORT;
                end
            end
            ST_RESPOND: state_nxt = ST_IDLE;
            default:    state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            code_q  <= RSP_OK;
            tmo_q   <= '0;
        end else begin
            state_q <= state_nxt;
            code_q  <= code_nxt;
            tmo_q   <= (state_q == ST_CYCLE) ? tmo_q + 1'b1 : '0;
        end
    end

    always_comb begin
        cyc_active = (state_q == ST_CYCLE);
        resp_valid = (state_q == ST_RESPOND);
        resp_code  = code_q;
        finish     = (state_nxt == ST_RESPOND) && (state_q != ST_RESPOND);
        fin_ok     = (code_nxt == RSP_OK);
        set_done   = finish && (code_nxt != RSP_INVALID);
        set_err    = finish && (code_nxt == RSP_ABORT);
    end
endmodule

// File: rtl/cfg_status.sv
module cfg_status (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic set_done,
    input  logic set_err,
    input  logic w1c_wr,
    input  logic w1c_done,
    input  logic w1c_err,
    output logic done_q,
    output logic err_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= set_done | (done_q & !clr & !(w1c_wr & w1c_done));
            err_q  <= set_err  | (err_q  & !clr & !(w1c_wr & w1c_err));
        end
    end
endmodule

// File: rtl/cfg_requester.sv
module cfg_requester
    import cfg_req_pkg::*;
#(
    parameter logic [31:0] AREA1_BASE  = 32'hC000_0000,
    parameter int          DEV_SHIFT   = 6,
    parameter int          MAX_DEV     = 15,
    parameter int          TIMEOUT_CYC = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_wr,
    input  logic [31:0] ctrl_wdata,
    input  logic        stat_wr,
    input  logic [31:0] stat_wdata,
    output logic [31:0] stat_word,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_wdata,
    output logic        resp_valid,
    output logic [1:0]  resp_code,
    output logic [31:0] resp_rdata,
    input  logic        dma_busy,
    output logic        cfg_req,
    output logic        cfg_write,
    output logic [7:0]  cfg_bus,
    output logic [7:0]  cfg_devfn,
    output logic [7:0]  cfg_reg,
    output logic [31:0] cfg_wdata,
    input  logic        cfg_ack,
    input  logic [31:0] cfg_rdata
);
    logic [7:0]  bus_sel_q;
    logic        dec_invalid, dec_abort;
    logic [7:0]  map_bus, map_devfn, map_reg;
    logic        accept, finish, fin_ok, set_done, set_err;
    logic        done_q, err_q;
    rsp_code_e   code;
    logic [31:0] rdata_q;
    logic        unused_bits;

    assign unused_bits = ^{ctrl_wdata[31:24], ctrl_wdata[15:0],
                           stat_wdata[31:21], stat_wdata[18:0]};

    always_ff @(posedge clk) begin
        if (!rst_n) bus_sel_q <= 8'h00;
        else if (ctrl_wr) bus_sel_q <= ctrl_wdata[23:16];
    end

    cfg_addr_decode #(
        .AREA1_BASE (AREA1_BASE),
        .DEV_SHIFT  (DEV_SHIFT),
        .MAX_DEV    (MAX_DEV)
    ) dec_i (
        .addr      (req_addr),
        .bus_sel   (bus_sel_q),
        .invalid   (dec_invalid),
        .dev_abort (dec_abort),
        .map_bus   (map_bus),
        .map_devfn (map_devfn),
        .map_reg   (map_reg)
    );

    cfg_req_fsm #(.TIMEOUT_CYC(TIMEOUT_CYC)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .dec_invalid (dec_invalid),
        .dec_abort   (dec_abort),
        .dma_busy    (dma_busy),
        .cfg_ack     (cfg_ack),
        .accept      (accept),
        .cyc_active  (cfg_req),
        .resp_valid  (resp_valid),
        .resp_code   (code),
        .finish      (finish),
        .fin_ok      (fin_ok),
        .set_done    (set_done),
        .set_err     (set_err)
    );

    cfg_status stat_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (accept),
        .set_done (set_done),
        .set_err  (set_err),
        .w1c_wr   (stat_wr),
        .w1c_done (stat_wdata[STAT_DONE_BIT]),
        .w1c_err  (stat_wdata[STAT_ERR_BIT]),
        .done_q   (done_q),
        .err_q    (err_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_write <= 1'b0;
            cfg_bus   <= 8'h00;
            cfg_devfn <= 8'h00;
            cfg_reg   <= 8'h00;
            cfg_wdata <= '0;
            rdata_q   <= '0;
        end else begin
            if (accept) begin
                cfg_write <= req_write;
                cfg_bus   <= map_bus;
                cfg_devfn <= map_devfn;
                cfg_reg   <= map_reg;
                cfg_wdata <= swap32(req_wdata);
            end
            if (finish) rdata_q <= fin_ok ? swap32(cfg_rdata) : '1;
        end
    end

    always_comb begin
        stat_word                = '0;
        stat_word[STAT_DONE_BIT] = done_q;
        stat_word[STAT_ERR_BIT]  = err_q;
        resp_code                = code;
        resp_rdata               = rdata_q;
    end
endmodule

// File: rtl/cfg_requester_chk.sv
module cfg_requester_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        dma_busy,
    input logic        cfg_req,
    input logic [7:0]  cfg_bus,
    input logic [7:0]  cfg_devfn,
    input logic [7:0]  cfg_reg,
    input logic        resp_valid,
    input logic [1:0]  resp_code,
    input logic [31:0] stat_word
);
    // R10
    no_cycle_under_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_req) |-> !$past(dma_busy));

    // R10
    done_clear_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> !stat_word[20]);

    // R2
    aligned_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> (cfg_reg[1:0] == 2'b00));

    // R5
    bus0_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && cfg_bus == 8'h00) |-> (cfg_devfn[7:3] >= 5'd6 || cfg_devfn == 8'h00));

    // R3
    fields_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && $past(cfg_req)) |-> ($stable(cfg_bus) && $stable(cfg_devfn) && $stable(cfg_reg)));

    // R12
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R11
    abort_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_code == 2'd1) |-> (stat_word[20] && stat_word[19]));
endmodule

bind cfg_requester cfg_requester_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .dma_busy   (dma_busy),
    .cfg_req    (cfg_req),
    .cfg_bus    (cfg_bus),
    .cfg_devfn  (cfg_devfn),
    .cfg_reg    (cfg_reg),
    .resp_valid (resp_valid),
    .resp_code  (resp_code),
    .stat_word  (stat_word)
);

// File: tb/cfg_requester_tb_top.sv
`timescale 1ns/1ps
module cfg_requester_tb_top;
    localparam int TMO = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [31:0] ctrl_wdata = '0;
    logic        stat_wr = 1'b0;
    logic [31:0] stat_wdata = '0;
    logic [31:0] stat_word;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        resp_valid;
    logic [1:0]  resp_code;
    logic [31:0] resp_rdata;
    logic        dma_busy = 1'b0;
    logic        cfg_req, cfg_write;
    logic [7:0]  cfg_bus, cfg_devfn, cfg_reg;
    logic [31:0] cfg_wdata;
    logic        cfg_ack = 1'b0;
    logic [31:0] cfg_rdata;

    always #2 clk = ~clk;

    cfg_requester #(.TIMEOUT_CYC(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .stat_wr(stat_wr), .stat_wdata(stat_wdata), .stat_word(stat_word),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_code(resp_code),
        .resp_rdata(resp_rdata), .dma_busy(dma_busy), .cfg_req(cfg_req),
        .cfg_write(cfg_write), .cfg_bus(cfg_bus), .cfg_devfn(cfg_devfn),
        .cfg_reg(cfg_reg), .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack),
        .cfg_rdata(cfg_rdata)
    );

    // ---------------- target model ----------------
    function automatic logic [31:0] bswap(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction
    function automatic logic [31:0] mdl_data(input logic [7:0] b, input logic [7:0] df, input logic [7:0] r);
        return {df, b, r, 8'h5A};
    endfunction
    function automatic logic present(input logic [7:0] b, input logic [7:0] df);
        logic [4:0] d;
        d = df[7:3];
        return (b == 8'h00 && (df == 8'h00 || (d >= 5'd6 && d <= 5'd9))) ||
               (b == 8'h02 && d == 5'd3);
    endfunction

    assign cfg_rdata = mdl_data(cfg_bus, cfg_devfn, cfg_reg);

    int          ack_cnt = 0;
    logic        seen = 1'b0;
    int          req_cycles = 0;
    logic [7:0]  cap_bus, cap_devfn, cap_reg;
    logic [31:0] cap_wdata;
    logic        cap_write;

    always @(negedge clk) begin
        if (cfg_req) begin
            seen       <= 1'b1;
            req_cycles <= req_cycles + 1;
            cap_bus    <= cfg_bus;
            cap_devfn  <= cfg_devfn;
            cap_reg    <= cfg_reg;
            cap_wdata  <= cfg_wdata;
            cap_write  <= cfg_write;
            if (ack_cnt == 2 && present(cfg_bus, cfg_devfn)) cfg_ack <= 1'b1;
            else cfg_ack <= 1'b0;
            ack_cnt <= ack_cnt + 1;
        end else begin
            cfg_ack <= 1'b0;
            ack_cnt <= 0;
        end
    end

    int resp_cnt = 0;
    always @(posedge clk) if (resp_valid) resp_cnt <= resp_cnt + 1;

    // ---------------- checking ----------------
    int checks = 0;
    int fails  = 0;
    logic finished = 1'b0;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_bus(input logic [7:0] b);
        @(negedge clk);
        ctrl_wr = 1'b1;
        ctrl_wdata = {8'hA5, b, 16'hBEEF};
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic w1c(input logic [31:0] d);
        @(negedge clk);
        stat_wr = 1'b1;
        stat_wdata = d;
        @(negedge clk);
        stat_wr = 1'b0;
    endtask

    logic [1:0]  got_code;
    logic [31:0] got_rdata, got_stat;

    task automatic issue(input logic wr, input logic [31:0] a, input logic [31:0] wd);
        int n;
        @(negedge clk);
        seen = 1'b0;
        req_cycles = 0;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!resp_valid && n < 400) begin
            @(negedge clk);
            n++;
        end
        got_code  = resp_code;
        got_rdata = resp_rdata;
        got_stat  = stat_word;
        @(negedge clk);
        chk(!resp_valid, "R12 response lasts one cycle", {31'd0, resp_valid}, 32'd0);
    endtask

    typedef struct packed {
        logic [7:0]  bus;
        logic        wr;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [1:0]  code;
        logic        cyc;
        logic [7:0]  ebus;
        logic [7:0]  edevfn;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{8'h00, 1'b0, 32'hC001_0104, 32'h0000_0000, 2'd0, 1'b1, 8'h00, 8'h31}, // R5 dev0 fn1
        '{8'h00, 1'b1, 32'hC001_1A08, 32'h1122_3344, 2'd0, 1'b1, 8'h00, 8'h4A}, // R5 dev3 fn2 write
        '{8'h02, 1'b0, 32'hC001_1810, 32'h0000_0000, 2'd0, 1'b1, 8'h02, 8'h18}, // R4
        '{8'h02, 1'b1, 32'hC001_1B3C, 32'hDEAD_BEEF, 2'd0, 1'b1, 8'h02, 8'h1B}, // R4 write
        '{8'hFF, 1'b0, 32'hC001_0000, 32'h0000_0000, 2'd0, 1'b1, 8'h00, 8'h00}, // R6 host
        '{8'h00, 1'b0, 32'hC001_8000, 32'h0000_0000, 2'd1, 1'b0, 8'h00, 8'h00}, // R7 dev16
        '{8'h00, 1'b0, 32'hC001_0102, 32'h0000_0000, 2'd2, 1'b0, 8'h00, 8'h00}, // R2 misaligned
        '{8'h00, 1'b0, 32'hC002_0000, 32'h0000_0000, 2'd2, 1'b0, 8'h00, 8'h00}, // R1 above window
        '{8'h00, 1'b0, 32'hC000_0100, 32'h0000_0000, 2'd2, 1'b0, 8'h00, 8'h00}, // R1 I/O half
        '{8'h05, 1'b0, 32'hC001_2000, 32'h0000_0000, 2'd1, 1'b1, 8'h05, 8'h20}, // R11 absent
        '{8'hFF, 1'b1, 32'hC001_0800, 32'h0102_0304, 2'd1, 1'b1, 8'hFF, 8'h08}  // R6 non-host on 0xFF
    };

    initial begin
        int rc0;
        logic ok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(stat_word == 32'd0 && !resp_valid && !cfg_req, "R9 reset state",
            {stat_word[31:2], resp_valid, cfg_req}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            set_bus(VEC[i].bus);
            w1c(32'hFFFF_FFFF);
            issue(VEC[i].wr, VEC[i].addr, VEC[i].wdata);
            chk(got_code == VEC[i].code, $sformatf("R12 code vec %0d", i),
                {30'd0, got_code}, {30'd0, VEC[i].code});
            chk(seen == VEC[i].cyc, $sformatf("R1 cycle issued vec %0d", i),
                {31'd0, seen}, {31'd0, VEC[i].cyc});
            if (VEC[i].cyc) begin
                chk(cap_bus == VEC[i].ebus && cap_devfn == VEC[i].edevfn,
                    $sformatf("R4 bus/devfn vec %0d", i),
                    {16'd0, cap_bus, cap_devfn}, {16'd0, VEC[i].ebus, VEC[i].edevfn});
                chk(cap_reg == VEC[i].addr[7:0] && cap_write == VEC[i].wr,
                    $sformatf("R3 offset vec %0d", i),
                    {23'd0, cap_write, cap_reg}, {23'd0, VEC[i].wr, VEC[i].addr[7:0]});
            end
            if (VEC[i].cyc && VEC[i].wr)
                chk(cap_wdata == bswap(VEC[i].wdata), $sformatf("R8 write swap vec %0d", i),
                    cap_wdata, bswap(VEC[i].wdata));
            if (VEC[i].code == 2'd0 && !VEC[i].wr)
                chk(got_rdata == bswap(mdl_data(VEC[i].ebus, VEC[i].edevfn, VEC[i].addr[7:0])),
                    $sformatf("R8 read swap vec %0d", i), got_rdata,
                    bswap(mdl_data(VEC[i].ebus, VEC[i].edevfn, VEC[i].addr[7:0])));
            if (VEC[i].code == 2'd1)
                chk(got_rdata == 32'hFFFF_FFFF, $sformatf("R7 abort data vec %0d", i),
                    got_rdata, 32'hFFFF_FFFF);
            if (VEC[i].code == 2'd1 && VEC[i].cyc)
                chk(req_cycles == TMO, $sformatf("R11 timeout length vec %0d", i),
                    req_cycles, TMO);
            begin
                logic [31:0] es;
                es = (VEC[i].code == 2'd2) ? 32'd0 :
                     (VEC[i].code == 2'd1) ? 32'h0018_0000 : 32'h0010_0000;
                chk(got_stat == es, $sformatf("R9 status vec %0d", i), got_stat, es);
            end
        end

        // R9 write-1-to-clear, one bit at a time (status now done+err)
        w1c(32'h0008_0000);
        chk(stat_word == 32'h0010_0000, "R9 clear error bit only", stat_word, 32'h0010_0000);
        w1c(32'hFFE7_FFFF);
        chk(stat_word == 32'h0010_0000, "R9 other bits ignored", stat_word, 32'h0010_0000);
        w1c(32'h0010_0000);
        chk(stat_word == 32'd0, "R9 clear done bit", stat_word, 32'd0);

        // R10 DMA stall; status done preset by a good cycle
        set_bus(8'h00);
        issue(1'b0, 32'hC001_0008, 32'd0);
        chk(stat_word == 32'h0010_0000, "R9 done after good cycle", stat_word, 32'h0010_0000);
        dma_busy = 1'b1;
        rc0 = resp_cnt;
        @(negedge clk);
        seen = 1'b0;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 32'hC001_0008;
        @(negedge clk);
        req_valid = 1'b0;
        ok = 1'b1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (cfg_req || stat_word[20]) ok = 1'b0;
            if (k == 4) req_valid = 1'b1;
            if (k == 5) req_valid = 1'b0;
        end
        chk(ok, "R10 no cycle and done clear during stall", {31'd0, ok}, 32'd1);
        dma_busy = 1'b0;
        for (int k = 0; k < 20; k++) @(negedge clk);
        chk(seen && cap_devfn == 8'h30, "R10 cycle after release", {23'd0, seen, cap_devfn}, {23'd0, 1'b1, 8'h30});
        chk(resp_cnt - rc0 == 1, "R12 busy request ignored", resp_cnt - rc0, 32'd1);

        // R2 rejection leaves status untouched (done still set)
        issue(1'b0, 32'hC001_0101, 32'd0);
        chk(got_code == 2'd2 && !seen, "R2 misaligned rejected", {29'd0, seen, got_code}, 32'd2);
        chk(stat_word == 32'h0010_0000, "R2 status unchanged", stat_word, 32'h0010_0000);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule